// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Controller

This block handles the entry into interrupt exception processing for a processor core. It watches a 3-bit pending priority level from the interrupt inputs and decides, at each instruction boundary the core signals, whether that level is taken. Levels 1 to 6 are masked by the status word's mask field. Level 7 is edge-triggered and cannot be masked. When a level is taken, the block keeps a copy of the incoming status word. It also builds the status word used during the handler: supervisor state on, every trace enable off, and the mask raised to the serviced level.

It then runs an interrupt acknowledge bus cycle. The cycle marks CPU space on the function code lines, asserts the address strobe and read, and puts the serviced level on address bits 3..1. The cycle stays open until the bus ends it, and the way it ends selects the vector. A normal data acknowledge takes the device byte from the low data lanes. An autovector request produces 24 plus the level. A bus error marks the interrupt as spurious and produces vector 24. A one-cycle done pulse then presents the vector number and its byte offset into the vector table to the exception sequencer.

Top module: `iack_vector_unit`

## Requirements
- R1: On the cycle an interrupt is taken, `savedSr` captures `srIn` exactly as it was, and holds it until the next interrupt is taken.
- R2: `newSr` is `srIn` from the taking cycle with bit 13 (supervisor) set, bits 15:14 (trace enables) cleared and all other bits except the mask unchanged.
- R3: Bits 10:8 of `newSr` (the interrupt mask) equal the level being serviced.
- R4: From the cycle after an interrupt is taken, `ackAs` and `ackRead` are 1, `ackFc` is 3'b111 and `ackAddrLvl` is the serviced level. They hold until a termination input is sampled high, and they drop in the following cycle.
- R5: If `busAvec` is high and `busBerr` is low at the terminating edge, the vector is 24 + level (25..31). The autovector wins over `busDtack`.
- R6: If `busBerr` is high at the terminating edge, the vector is 24 (spurious), whatever the other termination inputs are.
- R7: If only `busDtack` ends the cycle, the vector is `busData[7:0]` sampled at that edge.
- R8: Levels 1..6 are taken only when `instBoundary` is high, the block is idle and the level is strictly greater than `srIn[10:8]`. Level 0 is never taken.
- R9: Level 7 is taken regardless of the mask, once per low-to-high transition of the pending level to 7. A transition seen while busy or off-boundary is remembered until it is taken.
- R10: While an acknowledge cycle is open, new requests are ignored: the level, `savedSr` and `newSr` do not change.
- R11: `vecDone` is high for exactly one cycle, the cycle after the terminating edge. `vecNum` holds the vector from then on, and `vecOffset` equals `vecNum` * 4.
- R12: During reset the bus outputs and `vecDone` are 0, and `savedSr`, `newSr`, `vecNum` and `vecOffset` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pendLevel | input | 3 | Pending interrupt priority level |
| srIn | input | 16 | Current status word |
| instBoundary | input | 1 | Core is at an instruction boundary |
| busDtack | input | 1 | Data acknowledge ending the cycle |
| busAvec | input | 1 | Autovector request ending the cycle |
| busBerr | input | 1 | Bus error ending the cycle |
| busData | input | 32 | Data bus |
| ackFc | output | 3 | Function code, 3'b111 during acknowledge |
| ackAs | output | 1 | Address strobe of the acknowledge cycle |
| ackRead | output | 1 | Read strobe of the acknowledge cycle |
| ackAddrLvl | output | 3 | Serviced level, driven on address bits 3..1 |
| savedSr | output | 16 | Status word copy taken on entry |
| newSr | output | 16 | Status word for the handler |
| vecNum | output | 8 | Resolved vector number |
| vecOffset | output | 10 | Vector table byte offset |
| vecDone | output | 1 | One-cycle vector valid pulse |

## Verification
A wrong acceptance decision or a lost level-7 edge shows on `ackAs` one cycle after the boundary cycle concerned. A bad source priority shows on `vecNum` one cycle after the terminating edge. A corrupted entry capture shows on `savedSr` or `newSr` in the first cycle of the acknowledge. The bench keeps its own model of the pending edge, the busy state and every registered output, and compares them every cycle. A divergence is therefore reported within one clock of the edge that caused it.

// File: rtl/iack_pkg.sv
package iack_pkg;
  // status word layout
  localparam int SUPV_BIT = 13;
  localparam int TRACE_HI = 15;
  localparam int TRACE_LO = 14;
  localparam int MASK_HI  = 10;
  localparam int MASK_LO  = 8;

  typedef enum logic [1:0] {
    VSRC_DEV  = 2'd0,
    VSRC_AUTO = 2'd1,
    VSRC_SPUR = 2'd2
  } vecSrc_e;

  typedef struct packed {
    logic    captureEntry;
    logic    captureVec;
    vecSrc_e vecSrc;
  } dpCtl_t;
endpackage

// File: rtl/iack_ctrl.sv
module iack_ctrl
  import iack_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] pendLevel,
  input  logic [LVL_W-1:0] curMask,
  input  logic             instBoundary,
  input  logic             busDtack,
  input  logic             busAvec,
  input  logic             busBerr,
  output dpCtl_t           dpCtl,
  output logic             ackActive,
  output logic             vecDone
);
  localparam logic [LVL_W-1:0] TOP_LVL = {LVL_W{1'b1}};

  typedef enum logic {ST_IDLE, ST_ACK} state_e;

  state_e           state;
  logic [LVL_W-1:0] prevLvl;
  logic             topLatch;
  logic             topEdge;
  logic             topReq;
  logic             maskedOk;
  logic             accept;
  logic             cycleEnd;

  always_comb begin
    topEdge  = (pendLevel == TOP_LVL) && (prevLvl != TOP_LVL);
    topReq   = topLatch || topEdge;
    maskedOk = (pendLevel != '0) && (pendLevel != TOP_LVL) && (pendLevel > curMask);
    accept   = (state == ST_IDLE) && instBoundary &&
               (((pendLevel == TOP_LVL) && topReq) || maskedOk);
    cycleEnd = (state == ST_ACK) && (busDtack || busAvec || busBerr);
  end

  always_comb begin
    dpCtl.captureEntry = accept;
    dpCtl.captureVec   = cycleEnd;
    if (busBerr)      dpCtl.vecSrc = VSRC_SPUR;
    else if (busAvec) dpCtl.vecSrc = VSRC_AUTO;
    else              dpCtl.vecSrc = VSRC_DEV;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      prevLvl  <= '0;
      topLatch <= 1'b0;
      vecDone  <= 1'b0;
    end else begin
      prevLvl <= pendLevel;
      vecDone <= cycleEnd;
      if (accept && (pendLevel == TOP_LVL)) topLatch <= 1'b0;
      else if (topEdge)                     topLatch <= 1'b1;
      case (state)
        ST_IDLE: if (accept)   state <= ST_ACK;
        ST_ACK:  if (cycleEnd) state <= ST_IDLE;
        default:               state <= ST_IDLE;
      endcase
    end
  end

  assign ackActive = (state == ST_ACK);
endmodule

// File: rtl/iack_datapath.sv
module iack_datapath
  import iack_pkg::*;
#(
  parameter int LVL_W     = 3,
  parameter int SR_W      = 16,
  parameter int DATA_W    = 32,
  parameter int VEC_W     = 8,
  parameter int AUTO_BASE = 24,
  parameter int SPUR_VEC  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [LVL_W-1:0]  pendLevel,
  input  logic [SR_W-1:0]   srIn,
  input  logic [DATA_W-1:0] busData,
  output logic [SR_W-1:0]   savedSr,
  output logic [SR_W-1:0]   newSr,
  output logic [LVL_W-1:0]  svcLevel,
  output logic [VEC_W-1:0]  vecNum,
  output logic [VEC_W+1:0]  vecOffset
);
  localparam logic [VEC_W-1:0] AUTO_B = VEC_W'(AUTO_BASE);
  localparam logic [VEC_W-1:0] SPUR_V = VEC_W'(SPUR_VEC);

  logic [SR_W-1:0]  entrySr;
  logic [VEC_W-1:0] nextVec;

  always_comb begin
    entrySr = srIn;
    entrySr[SUPV_BIT] = 1'b1;
    for (int b = TRACE_LO; b <= TRACE_HI; b++) entrySr[b] = 1'b0;
    entrySr[MASK_HI:MASK_LO] = pendLevel;
  end

  always_comb begin
    case (dpCtl.vecSrc)
      VSRC_SPUR: nextVec = SPUR_V;
      VSRC_AUTO: nextVec = AUTO_B + VEC_W'(svcLevel);
      default:   nextVec = busData[VEC_W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedSr  <= '0;
      newSr    <= '0;
      svcLevel <= '0;
      vecNum   <= '0;
    end else begin
      if (dpCtl.captureEntry) begin
        savedSr  <= srIn;
        newSr    <= entrySr;
        svcLevel <= pendLevel;
      end
      if (dpCtl.captureVec) vecNum <= nextVec;
    end
  end

  assign vecOffset = {vecNum, 2'b00};
endmodule

// File: rtl/iack_vector_unit.sv
module iack_vector_unit
  import iack_pkg::*;
#(
  parameter int LVL_W     = 3,
  parameter int SR_W      = 16,
  parameter int DATA_W    = 32,
  parameter int VEC_W     = 8,
  parameter int FC_W      = 3,
  parameter int AUTO_BASE = 24,
  parameter int SPUR_VEC  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LVL_W-1:0]  pendLevel,
  input  logic [SR_W-1:0]   srIn,
  input  logic              instBoundary,
  input  logic              busDtack,
  input  logic              busAvec,
  input  logic              busBerr,
  input  logic [DATA_W-1:0] busData,
  output logic [FC_W-1:0]   ackFc,
  output logic              ackAs,
  output logic              ackRead,
  output logic [LVL_W-1:0]  ackAddrLvl,
  output logic [SR_W-1:0]   savedSr,
  output logic [SR_W-1:0]   newSr,
  output logic [VEC_W-1:0]  vecNum,
  output logic [VEC_W+1:0]  vecOffset,
  output logic              vecDone
);
  dpCtl_t           dpCtl;
  logic             ackActive;
  logic [LVL_W-1:0] svcLevel;

  iack_ctrl #(.LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .pendLevel(pendLevel),
    .curMask(srIn[MASK_HI:MASK_LO]), .instBoundary(instBoundary),
    .busDtack(busDtack), .busAvec(busAvec), .busBerr(busBerr),
    .dpCtl(dpCtl), .ackActive(ackActive), .vecDone(vecDone)
  );

  iack_datapath #(
    .LVL_W(LVL_W), .SR_W(SR_W), .DATA_W(DATA_W), .VEC_W(VEC_W),
    .AUTO_BASE(AUTO_BASE), .SPUR_VEC(SPUR_VEC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .pendLevel(pendLevel),
    .srIn(srIn), .busData(busData), .savedSr(savedSr), .newSr(newSr),
    .svcLevel(svcLevel), .vecNum(vecNum), .vecOffset(vecOffset)
  );

  assign ackAs      = ackActive;
  assign ackRead    = ackActive;
  assign ackFc      = ackActive ? {FC_W{1'b1}} : '0;
  assign ackAddrLvl = ackActive ? svcLevel : '0;
endmodule

// File: rtl/iack_vector_unit_chk.sv
module iack_vector_unit_chk
  import iack_pkg::*;
#(
  parameter int LVL_W     = 3,
  parameter int SR_W      = 16,
  parameter int DATA_W    = 32,
  parameter int VEC_W     = 8,
  parameter int AUTO_BASE = 24,
  parameter int SPUR_VEC  = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic [LVL_W-1:0]  pendLevel,
  input logic [SR_W-1:0]   srIn,
  input logic              instBoundary,
  input logic              busDtack,
  input logic              busAvec,
  input logic              busBerr,
  input logic [DATA_W-1:0] busData,
  input logic              ackAs,
  input logic              ackRead,
  input logic [LVL_W-1:0]  ackAddrLvl,
  input logic [SR_W-1:0]   savedSr,
  input logic [SR_W-1:0]   newSr,
  input logic [VEC_W-1:0]  vecNum,
  input logic              vecDone
);
  localparam logic [LVL_W-1:0] TOP_LVL = {LVL_W{1'b1}};
  logic anyEnd;
  assign anyEnd = busDtack || busAvec || busBerr;

  AST_SR_COPY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackAs) |-> savedSr == $past(srIn)); // R1
  AST_SR_SUPERVISOR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackAs) |-> (newSr[SUPV_BIT] && newSr[TRACE_HI:TRACE_LO] == '0)); // R2
  AST_SR_MASK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackAs) |-> newSr[MASK_HI:MASK_LO] == ackAddrLvl); // R3
  AST_CYCLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ackAs && !anyEnd) |=> (ackAs && ackRead && $stable(ackAddrLvl))); // R4
  AST_CYCLE_END: assert property (@(posedge clk) disable iff (!rstN)
    (ackAs && anyEnd) |=> !ackAs); // R4
  AST_AUTOVECTOR: assert property (@(posedge clk) disable iff (!rstN)
    (ackAs && busAvec && !busBerr) |=> vecNum == VEC_W'(AUTO_BASE) + VEC_W'($past(ackAddrLvl))); // R5
  AST_BERR_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    (ackAs && busBerr) |=> (vecDone && vecNum == VEC_W'(SPUR_VEC))); // R6
  AST_DEVICE_VEC: assert property (@(posedge clk) disable iff (!rstN)
    (ackAs && busDtack && !busAvec && !busBerr) |=> vecNum == $past(busData[VEC_W-1:0])); // R7
  AST_MASKED_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (!ackAs && instBoundary && pendLevel != TOP_LVL && pendLevel <= srIn[MASK_HI:MASK_LO]) |=> !ackAs); // R8
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (ackAs && !anyEnd) |=> ($stable(savedSr) && $stable(newSr))); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    vecDone |=> !vecDone); // R11
  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rstN)
    vecDone |-> $past(ackAs)); // R11
endmodule

bind iack_vector_unit iack_vector_unit_chk #(
  .LVL_W(LVL_W), .SR_W(SR_W), .DATA_W(DATA_W), .VEC_W(VEC_W),
  .AUTO_BASE(AUTO_BASE), .SPUR_VEC(SPUR_VEC)
) u_chk (
  .clk(clk), .rstN(rstN), .pendLevel(pendLevel), .srIn(srIn),
  .instBoundary(instBoundary), .busDtack(busDtack), .busAvec(busAvec),
  .busBerr(busBerr), .busData(busData), .ackAs(ackAs), .ackRead(ackRead),
  .ackAddrLvl(ackAddrLvl), .savedSr(savedSr), .newSr(newSr),
  .vecNum(vecNum), .vecDone(vecDone)
);

// File: tb/iack_vector_unit_bench.sv
module iack_vector_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  pendLevel = '0;
  logic [15:0] srIn = '0;
  logic        instBoundary = 1'b0;
  logic        busDtack = 1'b0, busAvec = 1'b0, busBerr = 1'b0;
  logic [31:0] busData = '0;
  logic [2:0]  ackFc;
  logic        ackAs, ackRead;
  logic [2:0]  ackAddrLvl;
  logic [15:0] savedSr, newSr;
  logic [7:0]  vecNum;
  logic [9:0]  vecOffset;
  logic        vecDone;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  iack_vector_unit u_iack_vector_unit (.*);

  // behavioural reference model
  bit        mBusy, mDone, mTop;
  int        mLvl, mPrev, mVec;
  bit [15:0] mSaved, mNew;
  string     mTag = "R12";

  always @(posedge clk) begin
    bit e7, took;
    cyc++;
    if (!rstN) begin
      mBusy = 0; mDone = 0; mTop = 0; mLvl = 0; mPrev = 0; mVec = 0;
      mSaved = 0; mNew = 0;
    end else begin
      e7 = (pendLevel == 7) && (mPrev != 7);
      took = 0;
      mDone = 0;
      if (mBusy) begin
        if (busDtack || busAvec || busBerr) begin
          if (busBerr)      begin mVec = 24;            mTag = "R6"; end
          else if (busAvec) begin mVec = 24 + mLvl;     mTag = "R5"; end
          else              begin mVec = busData[7:0];  mTag = "R7"; end
          mBusy = 0; mDone = 1;
        end
      end else if (instBoundary &&
                   ((pendLevel == 7 && (mTop || e7)) ||
                    (pendLevel != 0 && pendLevel != 7 && pendLevel > srIn[10:8]))) begin
        took = 1;
        mBusy = 1; mLvl = pendLevel; mSaved = srIn;
        mNew = srIn; mNew[13] = 1; mNew[15:14] = 0; mNew[10:8] = pendLevel;
      end
      if (took && pendLevel == 7) mTop = 0;
      else if (e7) mTop = 1;
      mPrev = pendLevel;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // every-cycle comparison; all outputs are registered
  always @(negedge clk) if (rstN) begin
    chk(ackAs == mBusy, "R8", ackAs, mBusy);
    chk(ackRead == mBusy && ackFc == (mBusy ? 3'd7 : 3'd0), "R4", ackFc, mBusy ? 7 : 0);
    if (mBusy) chk(ackAddrLvl == mLvl, "R4", ackAddrLvl, mLvl);
    chk(savedSr == mSaved, "R1", savedSr, mSaved);
    chk(newSr[15:11] == mNew[15:11] && newSr[7:0] == mNew[7:0], "R2", newSr, mNew);
    chk(newSr[10:8] == mNew[10:8], "R3", newSr[10:8], mNew[10:8]);
    chk(vecNum == mVec, mTag, vecNum, mVec);
    chk(vecOffset == mVec * 4 && vecDone == mDone, "R11", vecOffset, mVec * 4);
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // request, hold open for dly cycles, end with kind (0 dtack,1 avec,2 berr,3 all)
  task automatic irq(input int lvl, input bit [15:0] sr, input int dly, input int kind,
                     input bit [7:0] dat, input int expVec, input string tag);
    @(negedge clk);
    pendLevel = 3'(lvl); srIn = sr; instBoundary = 1;
    tick(1);
    instBoundary = 0;
    chk(ackAs == 1, tag, ackAs, 1);
    tick(dly);
    busData = {24'hA5A5A5, dat};
    busDtack = (kind == 0 || kind == 3);
    busAvec  = (kind == 1 || kind == 3);
    busBerr  = (kind == 2 || kind == 3);
    tick(1);
    busDtack = 0; busAvec = 0; busBerr = 0;
    chk(vecDone == 1 && vecNum == 8'(expVec), tag, vecNum, expVec);
    chk(vecOffset == 10'(expVec * 4), "R11", vecOffset, expVec * 4);
    tick(1);
    chk(vecDone == 0, "R11", vecDone, 0);
  endtask

  initial begin
    tick(3);
    chk(ackAs == 0 && ackRead == 0 && ackFc == 0 && vecDone == 0, "R12", ackAs, 0);
    chk(savedSr == 0 && newSr == 0 && vecNum == 0 && vecOffset == 0, "R12", vecNum, 0);
    rstN = 1;
    tick(2);

    irq(5, 16'hC203, 2, 0, 8'h9C, 8'h9C, "R7");
    chk(savedSr == 16'hC203, "R1", savedSr, 16'hC203);
    chk(newSr == 16'h2503, "R2", newSr, 16'h2503);
    irq(3, 16'h0100, 0, 1, 8'h00, 27, "R5");
    irq(6, 16'h8000, 4, 2, 8'h40, 24, "R6");
    irq(2, 16'h0000, 1, 3, 8'h77, 24, "R6");
    // avec beats dtack
    @(negedge clk); pendLevel = 4; srIn = 0; instBoundary = 1;
    tick(1); instBoundary = 0; busAvec = 1; busDtack = 1; busData = 32'h11;
    tick(1); busAvec = 0; busDtack = 0;
    chk(vecNum == 28, "R5", vecNum, 28);
    tick(1);

    // masked level: 3 against mask 3, and level 0
    pendLevel = 3; srIn = 16'h0300; instBoundary = 1;
    tick(1); chk(ackAs == 0, "R8", ackAs, 0);
    pendLevel = 0; srIn = 0;
    tick(1); chk(ackAs == 0, "R8", ackAs, 0);
    // no boundary: not taken
    pendLevel = 6; instBoundary = 0;
    tick(2); chk(ackAs == 0, "R8", ackAs, 0);

    // level 7 with mask 7: taken once per rise
    srIn = 16'h0700; pendLevel = 7; instBoundary = 1;
    tick(1); instBoundary = 0;
    chk(ackAs == 1 && ackAddrLvl == 7, "R9", ackAddrLvl, 7);
    busAvec = 1; tick(1); busAvec = 0;
    chk(vecNum == 31, "R5", vecNum, 31);
    instBoundary = 1; tick(3);
    chk(ackAs == 0, "R9", ackAs, 0);
    // rise while not at a boundary is remembered
    instBoundary = 0; pendLevel = 2; tick(1); pendLevel = 7; tick(3);
    chk(ackAs == 0, "R9", ackAs, 0);
    instBoundary = 1; tick(1); instBoundary = 0;
    chk(ackAs == 1, "R9", ackAs, 1);
    busBerr = 1; tick(1); busBerr = 0; pendLevel = 0; tick(1);

    // busy: a higher request is ignored
    srIn = 16'h0000; pendLevel = 2; instBoundary = 1;
    tick(1);
    pendLevel = 6; srIn = 16'hFFFF;
    tick(3);
    chk(ackAddrLvl == 2 && savedSr == 16'h0000, "R10", ackAddrLvl, 2);
    chk(newSr == 16'h2200, "R10", newSr, 16'h2200);
    instBoundary = 0; busDtack = 1; busData = 32'h5A; tick(1); busDtack = 0;
    chk(vecNum == 8'h5A, "R7", vecNum, 8'h5A);
    tick(2);

    // random traffic, checked every cycle by the model
    for (int i = 0; i < 4000; i++) begin
      pendLevel = 3'($urandom_range(0, 7));
      srIn = 16'($urandom);
      instBoundary = ($urandom_range(0, 3) != 0);
      busData = $urandom;
      busDtack = ($urandom_range(0, 5) == 0);
      busAvec  = ($urandom_range(0, 7) == 0);
      busBerr  = ($urandom_range(0, 9) == 0);
      tick(1);
    end
    busDtack = 0; busAvec = 0; busBerr = 0; instBoundary = 0;
    tick(3);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule